// File: doc/BRIEF.md
# Interrupt Entry Context Push Sequencer

When an interrupt is taken, this block saves the processor context to the stack in memory. On an accept strobe it captures the 20-bit program counter, the 16-bit flag word and the current stack pointer. It then writes a packed four-byte frame below that pointer through a valid/ready memory write port. When the last write has been taken, it pulses a done signal and presents the stack pointer minus four. Selecting which stack pointer to use, interrupt priority and vector fetch are handled elsewhere.

The write port issues one write at a time. A write can be 16 bits wide to an even address, or 8 bits wide to any address. The parity of the captured pointer decides the mix of writes. An even pointer gives two wide writes. An odd pointer gives four narrow writes. In both cases the half of the frame that holds the flags goes out before the program-counter half.

Back-pressure follows the usual rules. While `wr_valid_o` is high and `wr_ready_i` is low, the address, data and width do not change. A write counts as done on any clock edge where both are high. Nothing limits how long ready may stay low.

Top module: `ctx_push_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `wr_valid_o` and `done_o` are 0 and `sp_new_o` is 0 until the first save completes.
- R2: With an even captured pointer m, the block issues exactly two wide writes (`wr_wide_o`=1). The first goes to m-2 and the second to m-4.
- R3: With an odd captured pointer m, the block issues exactly four narrow writes (`wr_wide_o`=0), to m-1, m-2, m-3 and m-4 in that order.
- R4: Byte contents by address: m-1 holds flag bits [IPL_LSB+3:IPL_LSB] in bits 7:4 and PC bits 19:16 in bits 3:0. m-2 holds flag bits 7:0, m-3 holds PC bits 15:8 and m-4 holds PC bits 7:0. A wide write to address a carries byte a in `wr_data_o[7:0]` and byte a+1 in `wr_data_o[15:8]`. A narrow write carries its byte in `wr_data_o[7:0]`, with bits 15:8 set to zero.
- R5: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o` stays high and the address, data and width hold their values.
- R6: In the cycle after the final write is accepted, `done_o` is high for exactly one cycle. `sp_new_o` then equals m-4 and keeps that value until the next save completes.
- R7: An accept strobe that arrives while a save is in progress is ignored. No extra write is issued and the frame being written does not change.
- R8: A wide write never goes to an odd address.
- R9: All address arithmetic is modulo 2^SP_W, so a pointer near zero wraps to the top of the address space.
- R10: An accept strobe in the cycle where `done_o` is high starts a new save. Its first write is presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_i | input | 1 | Accept strobe; starts a save when the block is idle |
| pc_i | input | 20 | Program counter to save |
| flg_i | input | FLG_W | Flag word to save |
| sp_i | input | SP_W | Stack pointer at accept |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Memory accepts the write this cycle |
| wr_addr_o | output | SP_W | Byte address of the write |
| wr_data_o | output | 16 | Write data |
| wr_wide_o | output | 1 | 1 = 16-bit write, 0 = 8-bit write |
| done_o | output | 1 | One-cycle pulse after the frame is written |
| sp_new_o | output | SP_W | Updated stack pointer |

## Verification
The bench builds the block with its defaults: a 16-bit pointer, a 16-bit flag word and the priority nibble at bit 12. With a 16-bit pointer, starting values of 2 and 3 reach the wrap through zero within a single frame, and the bench uses both. A pseudo-random ready pattern stalls both the even and the odd sequence at every step. The bench also places accept strobes inside a save and on the done cycle, which exercises both the case where a strobe is ignored and the back-to-back restart.

// File: rtl/ctx_push_pkg.sv
package ctx_push_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PUSH = 1'b1
  } push_st_e;

  // byte3 lands at m-1, byte0 at m-4
  typedef struct packed {
    logic [7:0] byte3;
    logic [7:0] byte2;
    logic [7:0] byte1;
    logic [7:0] byte0;
  } ctx_frame_t;

  localparam int unsigned FRAME_BYTES = 4;
  localparam int unsigned WIDE_STEPS  = 2;
  localparam int unsigned NARROW_STEPS = 4;

endpackage

// File: rtl/ctx_frame_pack.sv
module ctx_frame_pack
  import ctx_push_pkg::*;
#(
  parameter int unsigned FLG_W   = 16,
  parameter int unsigned IPL_LSB = 12
) (
  input  logic [19:0]      pc_i,
  input  logic [FLG_W-1:0] flg_i,
  output ctx_frame_t       frame_o
);
  localparam int unsigned IPL_MSB = IPL_LSB + 3;

  always_comb begin
    frame_o.byte3 = {flg_i[IPL_MSB:IPL_LSB], pc_i[19:16]};
    frame_o.byte2 = flg_i[7:0];
    frame_o.byte1 = pc_i[15:8];
    frame_o.byte0 = pc_i[7:0];
  end
endmodule

// File: rtl/ctx_step_plan.sv
module ctx_step_plan
  import ctx_push_pkg::*;
#(
  parameter int unsigned SP_W = 16
) (
  input  ctx_frame_t      frame_i,
  input  logic [SP_W-1:0] base_i,
  input  logic            odd_i,
  input  logic [1:0]      step_i,
  output logic [SP_W-1:0] addr_o,
  output logic [15:0]     data_o,
  output logic            wide_o,
  output logic            last_o
);
  logic [SP_W-1:0] offset;
  logic [7:0]      pick;

  always_comb begin
    unique case (step_i)
      2'd0:    pick = frame_i.byte3;
      2'd1:    pick = frame_i.byte2;
      2'd2:    pick = frame_i.byte1;
      default: pick = frame_i.byte0;
    endcase
    if (odd_i) begin
      offset = SP_W'(step_i) + SP_W'(1);
      data_o = {8'h00, pick};
      wide_o = 1'b0;
      last_o = (step_i == 2'(NARROW_STEPS - 1));
    end else begin
      offset = SP_W'({step_i, 1'b0}) + SP_W'(2);
      data_o = step_i[0] ? {frame_i.byte1, frame_i.byte0}
                         : {frame_i.byte3, frame_i.byte2};
      wide_o = 1'b1;
      last_o = (step_i == 2'(WIDE_STEPS - 1));
    end
    addr_o = base_i - offset;
  end
endmodule

// File: rtl/ctx_push_seq.sv
module ctx_push_seq
  import ctx_push_pkg::*;
#(
  parameter int unsigned SP_W    = 16,
  parameter int unsigned FLG_W   = 16,
  parameter int unsigned IPL_LSB = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic [19:0]      pc_i,
  input  logic [FLG_W-1:0] flg_i,
  input  logic [SP_W-1:0]  sp_i,
  output logic             wr_valid_o,
  input  logic             wr_ready_i,
  output logic [SP_W-1:0]  wr_addr_o,
  output logic [15:0]      wr_data_o,
  output logic             wr_wide_o,
  output logic             done_o,
  output logic [SP_W-1:0]  sp_new_o
);
  localparam logic [SP_W-1:0] FRAME_SZ = SP_W'(FRAME_BYTES);

  push_st_e        st_q;
  ctx_frame_t      frame_q, frame_in;
  logic [SP_W-1:0] base_q;
  logic            odd_q;
  logic [1:0]      step_q;
  logic            done_q;
  logic [SP_W-1:0] sp_new_q;
  logic            last;

  ctx_frame_pack #(.FLG_W(FLG_W), .IPL_LSB(IPL_LSB)) u_pack (
    .pc_i    (pc_i),
    .flg_i   (flg_i),
    .frame_o (frame_in)
  );

  ctx_step_plan #(.SP_W(SP_W)) u_plan (
    .frame_i (frame_q),
    .base_i  (base_q),
    .odd_i   (odd_q),
    .step_i  (step_q),
    .addr_o  (wr_addr_o),
    .data_o  (wr_data_o),
    .wide_o  (wr_wide_o),
    .last_o  (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      frame_q  <= '0;
      base_q   <= '0;
      odd_q    <= 1'b0;
      step_q   <= '0;
      done_q   <= 1'b0;
      sp_new_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (acc_i) begin
          frame_q <= frame_in;
          base_q  <= sp_i;
          odd_q   <= sp_i[0];
          step_q  <= '0;
          st_q    <= ST_PUSH;
        end
        ST_PUSH: if (wr_ready_i) begin
          if (last) begin
            st_q     <= ST_IDLE;
            done_q   <= 1'b1;
            sp_new_q <= base_q - FRAME_SZ;
          end else begin
            step_q <= step_q + 2'd1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_valid_o = (st_q == ST_PUSH);
  assign done_o     = done_q;
  assign sp_new_o   = sp_new_q;
endmodule

// File: rtl/ctx_push_sva.sv
module ctx_push_sva #(
  parameter int unsigned SP_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_valid_o,
  input logic            wr_ready_i,
  input logic [SP_W-1:0] wr_addr_o,
  input logic [15:0]     wr_data_o,
  input logic            wr_wide_o,
  input logic            done_o,
  input logic [SP_W-1:0] sp_new_o
);
  logic [2:0] xfer_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    xfer_cnt <= '0;
    else if (done_o)               xfer_cnt <= '0;
    else if (wr_valid_o && wr_ready_i) xfer_cnt <= xfer_cnt + 3'd1;
  end

  // R5
  a_r5_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o)
      && $stable(wr_data_o) && $stable(wr_wide_o));

  // R8
  a_r8_wide_even: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_wide_o |-> !wr_addr_o[0]);

  // R6
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2 and R3: write count matches pointer parity
  a_r2_r3_write_count: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> xfer_cnt == (sp_new_o[0] ? 3'd4 : 3'd2));

  // R6: done never overlaps an open request
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_valid_o);
endmodule

bind ctx_push_seq ctx_push_sva #(.SP_W(SP_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .wr_wide_o  (wr_wide_o),
  .done_o     (done_o),
  .sp_new_o   (sp_new_o)
);

// File: tb/ctx_push_seq_tb.sv
module ctx_push_seq_tb;
  localparam int SP_W = 16;
  localparam int FLG_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc = 1'b0;
  logic [19:0] pc = '0;
  logic [FLG_W-1:0] flg = '0;
  logic [SP_W-1:0] sp = '0;
  logic rdy = 1'b1;
  logic wr_valid, wr_wide, done;
  logic [SP_W-1:0] wr_addr, sp_new;
  logic [15:0] wr_data;

  always #2.5 clk = ~clk;

  ctx_push_seq u_dut (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .pc_i(pc), .flg_i(flg), .sp_i(sp),
    .wr_valid_o(wr_valid), .wr_ready_i(rdy), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_wide_o(wr_wide), .done_o(done), .sp_new_o(sp_new)
  );

  typedef struct { logic [SP_W-1:0] a; logic [15:0] d; logic w; logic odd; } wr_t;
  wr_t q[$];
  logic done_exp = 1'b0;
  logic [SP_W-1:0] sp_exp = '0;
  logic [SP_W-1:0] cur_m = '0;
  int checks = 0, errors = 0, xfers = 0, cycles = 0;
  logic stall = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); done_exp = 1'b0; sp_exp = '0;
    end else begin
      done_exp = 1'b0;
      if (q.size() > 0) begin
        if (rdy) begin
          void'(q.pop_front());
          if (q.size() == 0) begin done_exp = 1'b1; sp_exp = cur_m - SP_W'(4); end
        end
      end else if (acc) begin
        logic [7:0] hb;
        cur_m = sp;
        hb = {flg[15:12], pc[19:16]};
        if (!sp[0]) begin
          q.push_back('{sp - SP_W'(2), {hb, flg[7:0]}, 1'b1, 1'b0});
          q.push_back('{sp - SP_W'(4), pc[15:0], 1'b1, 1'b0});
        end else begin
          q.push_back('{sp - SP_W'(1), {8'h00, hb}, 1'b0, 1'b1});
          q.push_back('{sp - SP_W'(2), {8'h00, flg[7:0]}, 1'b0, 1'b1});
          q.push_back('{sp - SP_W'(3), {8'h00, pc[15:8]}, 1'b0, 1'b1});
          q.push_back('{sp - SP_W'(4), {8'h00, pc[7:0]}, 1'b0, 1'b1});
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      chk("R1 valid in reset", 32'(wr_valid), 0);
      chk("R1 done in reset", 32'(done), 0);
    end else begin
      chk("R5 valid", 32'(wr_valid), 32'(q.size() > 0));
      if (wr_valid && q.size() > 0) begin
        chk(q[0].odd ? "R3 addr" : "R2 addr", 32'(wr_addr), 32'(q[0].a));
        chk("R4 data", 32'(wr_data), 32'(q[0].d));
        chk(q[0].odd ? "R3 width" : "R2 width", 32'(wr_wide), 32'(q[0].w));
        if (wr_wide) chk("R8 even", 32'(wr_addr[0]), 0);
        if (rdy) xfers++;
      end
      chk("R6 done", 32'(done), 32'(done_exp));
      chk(cur_m < 4 ? "R9 sp_new" : "R6 sp_new", 32'(sp_new), 32'(sp_exp));
    end
  end

  // ready pattern driven on the falling edge
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rdy  = stall ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (q.size() == 0 && !done_exp) break;
    end
  endtask

  task automatic launch(logic [19:0] p, logic [15:0] f, logic [SP_W-1:0] s);
    @(negedge clk);
    acc = 1'b1; pc = p; flg = f; sp = s;
    @(negedge clk);
    acc = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp_new after reset", 32'(sp_new), 0);
    chk("R1 valid after reset", 32'(wr_valid), 0);

    // R2 even, R3 odd, ready always high
    launch(20'hA1234, 16'h5C3E, 16'h1000); wait_idle();
    launch(20'h5ABCD, 16'h9F71, 16'h2001); wait_idle();

    // R5 stalls
    stall = 1'b1;
    launch(20'hF0F0F, 16'hE0AA, 16'h3002); wait_idle();
    launch(20'h12345, 16'h7055, 16'h4567); wait_idle();
    launch(20'h0FEDC, 16'h1234, 16'h0100); wait_idle();
    stall = 1'b0;

    // R7: accept during a save is ignored
    xfers = 0;
    launch(20'h11111, 16'h2222, 16'h5000);
    acc = 1'b1; pc = 20'hBBBBB; flg = 16'hCCCC; sp = 16'h6003;
    @(negedge clk);
    acc = 1'b0;
    wait_idle();
    chk("R7 write count", 32'(xfers), 2);
    chk("R7 sp_new", 32'(sp_new), 32'h4FFC);

    // R9 wrap, even then odd
    launch(20'h3C3C3, 16'hB00B, 16'h0002); wait_idle();
    chk("R9 even wrap", 32'(sp_new), 32'hFFFE);
    launch(20'h6D6D6, 16'hA0C1, 16'h0003); wait_idle();
    chk("R9 odd wrap", 32'(sp_new), 32'hFFFF);

    // R10 accept on the done cycle
    launch(20'h2468A, 16'h4321, 16'h7000);
    for (int i = 0; i < 50; i++) begin
      if (done) break;
      @(negedge clk);
    end
    acc = 1'b1; pc = 20'h13579; flg = 16'h8765; sp = 16'h7101;
    @(negedge clk);
    acc = 1'b0;
    chk("R10 restart valid", 32'(wr_valid), 1);
    chk("R10 restart addr", 32'(wr_addr), 32'h7100);
    wait_idle();
    chk("R10 final sp", 32'(sp_new), 32'h70FD);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule